// File: doc/BRIEF.md
# Microcoded Protocol Control Sequencer

This block is a small microprogrammed controller for a network protocol engine. One free-running divider makes two enables from the system clock: a fetch enable at one quarter of the clock rate and an execute enable at one eighth. Every instruction is two bytes long. On two fetch enables in a row, a 10-bit program counter steps through an internal 544 x 8 microprogram ROM. The opcode byte is latched on the first of these enables and the immediate byte on the second. The pair is then decoded and acted on at the next execute enable.

There are three instruction classes:
- A wait class freezes the program counter for a timed number of execute periods.
- A jump class reloads the program counter from the instruction bytes.
- A strobe class drives the immediate byte onto the decoded control-strobe output for one clock.

A reconfiguration-timeout input overrides all of these. In any phase it clears the program counter and sets a sticky status flag, and only a host clear strobe drops the flag. The ROM holds a short built-in test microprogram.

Top module: `useq_core`

## Requirements
- R1: The ROM holds 544 bytes and the 10-bit program counter never leaves 0..543. Incrementing from 543 wraps to 0, and a jump target of 544 or above restarts at 0.
- R2: A 3-bit divider counter starts at 0 after reset and counts every clock. `pc_tick` is high when the low two bits are 3 (one clock in four). `exe_tick` is high when the count is 7 (one clock in eight). `exe_tick` is never high without `pc_tick`.
- R3: Starting in the opcode phase, one `pc_tick` latches ROM[pc] as the opcode byte and the next latches ROM[pc] as the immediate byte. The program counter advances by one on each of these two ticks and changes at no other tick except by jump or timeout.
- R4: The opcode field is bits 7..2 of the opcode byte. Field 0 is a wait. At execute it holds the program counter for N execute periods, where N is the immediate byte and 0 counts as 1. Fetching then resumes.
- R5: Field 4 is a jump. At execute it loads the program counter with {opcode bits 1..0, immediate byte}.
- R6: Field 8 is a strobe. At execute `ctrl_strobe` equals the immediate byte for exactly one clock. It is zero in every other clock. Any other field value only returns to fetching.
- R7: A high `recon_timeout` clears the program counter to 0 on the next clock, sets `recon_flag`, and restarts at the opcode phase. It overrides a jump or wait executing in the same clock.
- R8: `recon_flag` stays set until a clock with `recon_clr` high and `recon_timeout` low. When both are high the flag is set.
- R9: After reset the program counter, `recon_flag` and `ctrl_strobe` are all zero.
- R10: The ROM holds this test program, given as address: opcode, immediate (hex). All other even addresses hold F0, and odd addresses hold their low address byte.
  - 000: 20 11
  - 002: 00 03
  - 004: 20 22
  - 006: 00 00
  - 008: 12 10
  - 210: 20 A5
  - 212: 12 1A
  - 21A: F0 77
  - 21C: 20 5A
  - 21E: 20 3C

  Run from reset without a timeout, it strobes 11, 22, A5, 5A, 3C in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recon_timeout | input | 1 | Reconfiguration timer expiry |
| recon_clr | input | 1 | Host clear of the reconfiguration flag |
| ctrl_strobe | output | 8 | Decoded control strobe byte, zero when idle |
| recon_flag | output | 1 | Sticky reconfiguration status |
| pc_o | output | 10 | Microprogram counter |
| pc_tick | output | 1 | Fetch enable (clock / 4) |
| exe_tick | output | 1 | Execute enable (clock / 8) |

## Verification
The assertions check the following on every clock:
- the ordering of the two enables;
- that the program counter holds except on a fetch enable;
- that it is frozen during a wait;
- that it lands on the jump target;
- that a timeout forces zero and sets the flag;
- the flag's hold and clear rules;
- the address range.

Other behaviour only shows up over whole scenarios, and the bench's cycle-level reference model checks it:
- the two-byte fetch order;
- the exact wait length including the zero case;
- the strobe sequence of the test program;
- the wrap from 543;
- a timeout landing on the same clock as a jump.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_IMM  = 2'd1,
    PH_EXE  = 2'd2,
    PH_WAIT = 2'd3
  } phase_t;

  localparam int WORD_W = 8;
  localparam int FIELD_W = 6;

  localparam logic [FIELD_W-1:0] FLD_WAIT   = 6'd0;
  localparam logic [FIELD_W-1:0] FLD_JUMP   = 6'd4;
  localparam logic [FIELD_W-1:0] FLD_STROBE = 6'd8;

  // opcode field sits in the upper bits of the opcode byte
  function automatic logic [FIELD_W-1:0] op_field(input logic [WORD_W-1:0] opc);
    return opc[WORD_W-1:WORD_W-FIELD_W];
  endfunction

  // wait length in execute periods; zero is treated as one
  function automatic logic [WORD_W-1:0] wait_len(input logic [WORD_W-1:0] imm);
    return (imm == '0) ? WORD_W'(1) : imm;
  endfunction

endpackage

// File: rtl/useq_tick_gen.sv
module useq_tick_gen #(
  parameter int PC_DIV  = 4,
  parameter int EXE_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic pc_tick,
  output logic exe_tick
);

  localparam int CW = $clog2(EXE_DIV);
  localparam logic [CW-1:0] TOP = CW'(EXE_DIV - 1);

  logic [CW-1:0] cnt;

  generate
    if ((EXE_DIV & (EXE_DIV - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CW'(1);
      end
    end else begin : g_mod
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == TOP) cnt <= '0;
        else                 cnt <= cnt + CW'(1);
      end
    end
  endgenerate

  assign pc_tick  = ((int'(cnt) % PC_DIV) == (PC_DIV - 1));
  assign exe_tick = (cnt == TOP);

endmodule

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int DEPTH = 544,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  // built-in test microprogram; unlisted words are filler
  function automatic logic [DW-1:0] prog_byte(input logic [AW-1:0] a);
    logic [DW-1:0] fill;
    fill = a[0] ? a[DW-1:0] : DW'(8'hF0);
    if (int'(a) >= DEPTH) return '0;
    case (int'(a))
      0:   return DW'(8'h20);
      1:   return DW'(8'h11);
      2:   return DW'(8'h00);
      3:   return DW'(8'h03);
      4:   return DW'(8'h20);
      5:   return DW'(8'h22);
      6:   return DW'(8'h00);
      7:   return DW'(8'h00);
      8:   return DW'(8'h12);
      9:   return DW'(8'h10);
      528: return DW'(8'h20);
      529: return DW'(8'hA5);
      530: return DW'(8'h12);
      531: return DW'(8'h1A);
      538: return DW'(8'hF0);
      539: return DW'(8'h77);
      540: return DW'(8'h20);
      541: return DW'(8'h5A);
      542: return DW'(8'h20);
      543: return DW'(8'h3C);
      default: return fill;
    endcase
  endfunction

  assign data = prog_byte(addr);

endmodule

// File: rtl/useq_recon_flag.sv
module useq_recon_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int ROM_DEPTH = 544,
  parameter int PC_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_tick,
  input  logic              exe_tick,
  input  logic              recon_timeout,
  input  logic [WORD_W-1:0] rom_data,
  output logic [PC_W-1:0]   pc,
  output logic [WORD_W-1:0] ctrl_strobe,
  output logic              wait_active,
  output logic              jump_fire,
  output logic [PC_W-1:0]   jump_dest
);

  localparam int HI_W = PC_W - WORD_W;
  localparam logic [PC_W-1:0] LAST_ADDR = PC_W'(ROM_DEPTH - 1);

  phase_t            phase;
  logic [WORD_W-1:0] opc_q;
  logic [WORD_W-1:0] imm_q;
  logic [WORD_W-1:0] wait_q;
  logic              exec_now;

  function automatic logic [PC_W-1:0] step_pc(input logic [PC_W-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] make_target(input logic [WORD_W-1:0] opc,
                                                  input logic [WORD_W-1:0] imm);
    logic [PC_W-1:0] t;
    t = {opc[HI_W-1:0], imm};
    return (t > LAST_ADDR) ? '0 : t;
  endfunction

  assign exec_now    = (phase == PH_EXE) && exe_tick;
  assign wait_active = (phase == PH_WAIT);
  assign jump_fire   = exec_now && (op_field(opc_q) == FLD_JUMP);
  assign jump_dest   = make_target(opc_q, imm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_OPC;
      pc          <= '0;
      opc_q       <= '0;
      imm_q       <= '0;
      wait_q      <= '0;
      ctrl_strobe <= '0;
    end else begin
      ctrl_strobe <= '0;
      if (recon_timeout) begin
        pc     <= '0;
        phase  <= PH_OPC;
        wait_q <= '0;
      end else begin
        unique case (phase)
          PH_OPC: if (pc_tick) begin
            opc_q <= rom_data;
            pc    <= step_pc(pc);
            phase <= PH_IMM;
          end
          PH_IMM: if (pc_tick) begin
            imm_q <= rom_data;
            pc    <= step_pc(pc);
            phase <= PH_EXE;
          end
          PH_EXE: if (exe_tick) begin
            phase <= PH_OPC;
            case (op_field(opc_q))
              FLD_WAIT: begin
                wait_q <= wait_len(imm_q);
                phase  <= PH_WAIT;
              end
              FLD_JUMP:   pc          <= jump_dest;
              FLD_STROBE: ctrl_strobe <= imm_q;
              default:    ;
            endcase
          end
          PH_WAIT: if (exe_tick) begin
            if (wait_q <= WORD_W'(1)) phase  <= PH_OPC;
            else                      wait_q <= wait_q - WORD_W'(1);
          end
          default: phase <= PH_OPC;
        endcase
      end
    end
  end

endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int ROM_DEPTH = 544,
  parameter int PC_DIV    = 4,
  parameter int EXE_DIV   = 8,
  parameter int PC_W      = $clog2(ROM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recon_timeout,
  input  logic              recon_clr,
  output logic [7:0]        ctrl_strobe,
  output logic              recon_flag,
  output logic [PC_W-1:0]   pc_o,
  output logic              pc_tick,
  output logic              exe_tick
);

  logic [WORD_W-1:0] rom_data;
  logic              wait_active;
  logic              jump_fire;
  logic [PC_W-1:0]   jump_dest;

  useq_tick_gen #(.PC_DIV(PC_DIV), .EXE_DIV(EXE_DIV)) u_ticks (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_tick  (pc_tick),
    .exe_tick (exe_tick)
  );

  useq_rom #(.DEPTH(ROM_DEPTH), .AW(PC_W), .DW(WORD_W)) u_rom (
    .addr (pc_o),
    .data (rom_data)
  );

  useq_ctrl #(.ROM_DEPTH(ROM_DEPTH), .PC_W(PC_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_tick       (pc_tick),
    .exe_tick      (exe_tick),
    .recon_timeout (recon_timeout),
    .rom_data      (rom_data),
    .pc            (pc_o),
    .ctrl_strobe   (ctrl_strobe),
    .wait_active   (wait_active),
    .jump_fire     (jump_fire),
    .jump_dest     (jump_dest)
  );

  useq_recon_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (recon_timeout),
    .clr_i  (recon_clr),
    .flag_o (recon_flag)
  );

endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk #(
  parameter int ROM_DEPTH = 544,
  parameter int PC_W      = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            recon_timeout,
  input logic            recon_clr,
  input logic            recon_flag,
  input logic            pc_tick,
  input logic            exe_tick,
  input logic            wait_active,
  input logic            jump_fire,
  input logic [PC_W-1:0] jump_dest,
  input logic [PC_W-1:0] pc_o
);

  assert_pc_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pc_o) < ROM_DEPTH);

  assert_exe_in_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exe_tick |-> pc_tick);

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_tick |=> !pc_tick);

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_tick && !recon_timeout) |=> $stable(pc_o));

  assert_wait_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_active && !recon_timeout) |=> $stable(pc_o));

  assert_jump_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_fire && !recon_timeout) |=> (pc_o == $past(jump_dest)));

  assert_timeout_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recon_timeout |=> (pc_o == '0 && recon_flag));

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_flag && !recon_clr) |=> recon_flag);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_clr && !recon_timeout) |=> !recon_flag);

endmodule

bind useq_core useq_core_chk #(.ROM_DEPTH(ROM_DEPTH), .PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .recon_timeout (recon_timeout),
  .recon_clr     (recon_clr),
  .recon_flag    (recon_flag),
  .pc_tick       (pc_tick),
  .exe_tick      (exe_tick),
  .wait_active   (wait_active),
  .jump_fire     (jump_fire),
  .jump_dest     (jump_dest),
  .pc_o          (pc_o)
);

// File: tb/useq_core_tb.sv
`timescale 1ns/1ps
module useq_core_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       recon_timeout = 1'b0;
  logic       recon_clr = 1'b0;
  logic [7:0] ctrl_strobe;
  logic       recon_flag;
  logic [9:0] pc_o;
  logic       pc_tick;
  logic       exe_tick;

  always #4 clk = ~clk;

  useq_core u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .recon_timeout (recon_timeout),
    .recon_clr     (recon_clr),
    .ctrl_strobe   (ctrl_strobe),
    .recon_flag    (recon_flag),
    .pc_o          (pc_o),
    .pc_tick       (pc_tick),
    .exe_tick      (exe_tick)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int    m_pc, m_ph, m_op, m_imm, m_wait, m_flag, m_stb;
  string m_why;
  int    k;
  int    seen[$];

  function automatic int rom_ref(int a);
    case (a)
      0: return 'h20;   1: return 'h11;   2: return 'h00;   3: return 'h03;
      4: return 'h20;   5: return 'h22;   6: return 'h00;   7: return 'h00;
      8: return 'h12;   9: return 'h10;
      528: return 'h20; 529: return 'hA5; 530: return 'h12; 531: return 'h1A;
      538: return 'hF0; 539: return 'h77; 540: return 'h20; 541: return 'h5A;
      542: return 'h20; 543: return 'h3C;
      default: return (a % 2 == 1) ? (a % 256) : 'hF0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, k);
    end
  endtask

  function automatic void advance_pc();
    m_pc = m_pc + 1;
    if (m_pc == 544) begin m_pc = 0; m_why = "R1 wrap"; end
    else m_why = "R3 fetch";
  endfunction

  function automatic void model(input bit to, input bit clr, input bit pt, input bit et);
    int fld, tgt;
    m_stb = 0;
    if (to) m_flag = 1;
    else if (clr) m_flag = 0;
    if (to) begin
      m_pc = 0; m_ph = 0; m_why = "R7 timeout";
      return;
    end
    case (m_ph)
      0: if (pt) begin m_op = rom_ref(m_pc); advance_pc(); m_ph = 1; end
      1: if (pt) begin m_imm = rom_ref(m_pc); advance_pc(); m_ph = 2; end
      2: if (et) begin
        fld = m_op / 4;
        m_ph = 0;
        if (fld == 0) begin
          m_wait = (m_imm == 0) ? 1 : m_imm; m_ph = 3; m_why = "R4 wait";
        end else if (fld == 4) begin
          tgt = (m_op % 4) * 256 + m_imm;
          m_pc = (tgt >= 544) ? 0 : tgt; m_why = "R5 jump";
        end else if (fld == 8) begin
          m_stb = m_imm; m_why = "R6 strobe";
        end else m_why = "R6 other field";
      end
      3: if (et) begin
        if (m_wait <= 1) m_ph = 0; else m_wait--;
        m_why = "R4 wait";
      end
      default: ;
    endcase
  endfunction

  // called at a negedge: compare, drive, predict, advance one clock
  task automatic step(input bit to, input bit clr);
    check(m_why, pc_o, m_pc);
    check("R8 flag", recon_flag, m_flag);
    check("R6 strobe", ctrl_strobe, m_stb);
    check("R2 pc_tick", pc_tick, (k % 4 == 3));
    check("R2 exe_tick", exe_tick, (k % 8 == 7));
    if (ctrl_strobe != 0) seen.push_back(ctrl_strobe);
    recon_timeout = to;
    recon_clr = clr;
    model(to, clr, pc_tick, exe_tick);
    @(negedge clk);
    k++;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit hit;
    int exp_seq[5] = '{'h11, 'h22, 'hA5, 'h5A, 'h3C};
    void'($urandom(32'd20240611));
    m_pc = 0; m_ph = 0; m_op = 0; m_imm = 0; m_wait = 0; m_flag = 0; m_stb = 0;
    m_why = "R9 reset"; k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check("R9 pc", pc_o, 0);
    check("R9 flag", recon_flag, 0);
    check("R9 strobe", ctrl_strobe, 0);

    // clean run through the test program including the wrap
    for (int i = 0; i < 420; i++) step(0, 0);
    for (int i = 0; i < 5; i++)
      check("R10 program strobe order", (i < seen.size()) ? seen[i] : -1, exp_seq[i]);

    // timeout on the same clock as a jump execute
    hit = 0;
    for (int i = 0; i < 600 && !hit; i++) begin
      if (m_ph == 2 && m_op / 4 == 4 && exe_tick) begin hit = 1; step(1, 0); end
      else step(0, 0);
    end
    check("R7 jump collision reached", hit, 1);
    step(0, 0);
    check("R7 pc after collision", pc_o, 0);

    // clear, then timeout during a wait
    step(0, 1);
    check("R8 cleared", recon_flag, 0);
    hit = 0;
    for (int i = 0; i < 600 && !hit; i++) begin
      if (m_ph == 3) begin hit = 1; step(1, 0); end
      else step(0, 0);
    end
    check("R7 wait interrupt reached", hit, 1);
    step(0, 0);
    check("R7 flag after wait interrupt", recon_flag, 1);

    // set beats clear
    step(0, 1);
    step(1, 1);
    step(0, 0);
    check("R8 set wins over clear", recon_flag, 1);

    // random mix
    for (int i = 0; i < 8000; i++)
      step(($urandom % 500) == 0, ($urandom % 60) == 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule